// File: doc/BRIEF.md
# Dimension-Order Mesh Header Router

This block is the header stage of a switch in a two-dimensional mesh. Each packet header carries a signed relative offset: the number of hops still to go in x and in y, plus a tag field that the block passes through untouched. On each accepted header the block picks one of five exits and rewrites the offset so that it moves one step toward zero in the dimension the packet is about to travel. The five exits are the four compass neighbours and the local processor.

The x offset is always cleared before any y movement starts. Once a header leaves on a north or south exit, its x offset is zero, and it can never turn back into x. This ordering of channel use is what keeps the mesh free of deadlock.

The input side is a valid/ready handshake. The result sits in a single output register that holds steady while the downstream side stalls. Arbitration between inputs, virtual channels and the payload path belong to neighbouring blocks.

Top module: `dor_mesh_router`

## Requirements
- R1: When dx (two's complement) is above zero, the exit code is 1 (East) and dx is decremented by one. When dx is below zero, the exit code is 2 (West) and dx is incremented by one. In both cases dy is left unchanged.
- R2: When dx is zero and dy is above zero, the exit code is 3 (North) and dy is decremented by one. When dx is zero and dy is below zero, the exit code is 4 (South) and dy is incremented by one. In both cases dx stays zero.
- R3: When both offsets are zero, the exit code is 0 (local processor) and both offsets come out unchanged.
- R4: Each routed header has exactly one offset field changed, by exactly one, or none for local delivery. The tag comes out identical to the tag that went in.
- R5: Whenever the exit code is North or South, the output dx is zero. A packet never moves in y while x distance remains.
- R6: A header is taken when in_valid and in_ready are both high, and its result appears with out_valid high after the next rising clock edge. in_ready equals (not out_valid) or out_ready.
- R7: While out_valid is high and out_ready is low, out_valid, out_port, out_dx, out_dy and out_tag keep their values.
- R8: During and right after a synchronous active-low reset, out_valid is low.
- R9: Offsets at the extremes step without wrapping: +127 becomes +126 on East or North, and -128 becomes -127 on West or South.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header present on the input |
| in_ready | output | 1 | Block can take a header this cycle |
| in_dx | input | OFS_W | Signed x hops remaining |
| in_dy | input | OFS_W | Signed y hops remaining |
| in_tag | input | TAG_W | Header bits passed through |
| out_valid | output | 1 | Rewritten header present |
| out_ready | input | 1 | Downstream takes the output |
| out_port | output | 3 | Exit: 0 local, 1 East, 2 West, 3 North, 4 South |
| out_dx | output | OFS_W | Rewritten x offset |
| out_dy | output | OFS_W | Rewritten y offset |
| out_tag | output | TAG_W | Tag, unchanged |

## Verification
The exit code and the rewritten offsets are due exactly one rising edge after the cycle in which the header is taken. in_ready is due in the same cycle, as a combinational result of the output register state and out_ready. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It then compares every output at the following falling edge, so each result is read in the cycle it is due and never earlier. Stalled cycles are compared in the same way, which checks that the held header does not move.

// File: rtl/mesh_rt_pkg.sv
// Package: shared exit codes for the dimension-order router.
// Assumes: a 3-bit exit select field is decoded by the crossbar next door.
package mesh_rt_pkg;
    typedef enum logic [2:0] {
        EXIT_LOCAL = 3'd0,
        EXIT_EAST  = 3'd1,
        EXIT_WEST  = 3'd2,
        EXIT_NORTH = 3'd3,
        EXIT_SOUTH = 3'd4
    } exit_e;

    localparam int EXIT_W = 3;
endpackage

// File: rtl/dor_dir_decode.sv
// Module: chooses the exit from the signed offsets, x before y.
// Assumes: offsets are two's complement of width OFS_W.
module dor_dir_decode
    import mesh_rt_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  logic [OFS_W-1:0] dx,
    input  logic [OFS_W-1:0] dy,
    output exit_e            sel
);
    localparam logic [OFS_W-1:0] ZERO = '0;

    logic dx_neg, dx_zero, dy_neg, dy_zero;

    // Sign and zero flags per dimension.
    always_comb begin
        dx_neg  = dx[OFS_W-1];
        dy_neg  = dy[OFS_W-1];
        dx_zero = (dx == ZERO);
        dy_zero = (dy == ZERO);
    end

    // Priority: any x distance first, then y, else local delivery.
    always_comb begin
        if (!dx_zero)
            sel = dx_neg ? EXIT_WEST : EXIT_EAST;
        else if (!dy_zero)
            sel = dy_neg ? EXIT_SOUTH : EXIT_NORTH;
        else
            sel = EXIT_LOCAL;
    end
endmodule

// File: rtl/dor_offset_step.sv
// Module: moves the offset of the travelled dimension one step toward zero.
// Assumes: sel came from dor_dir_decode, so the stepped field is never zero
// and a step toward zero cannot wrap.
module dor_offset_step
    import mesh_rt_pkg::*;
#(
    parameter int OFS_W = 8
) (
    input  exit_e            sel,
    input  logic [OFS_W-1:0] dx,
    input  logic [OFS_W-1:0] dy,
    output logic [OFS_W-1:0] dx_next,
    output logic [OFS_W-1:0] dy_next
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    // One field changes per hop; local delivery leaves both alone.
    always_comb begin
        dx_next = dx;
        dy_next = dy;
        unique case (sel)
            EXIT_EAST:  dx_next = dx - ONE;
            EXIT_WEST:  dx_next = dx + ONE;
            EXIT_NORTH: dy_next = dy - ONE;
            EXIT_SOUTH: dy_next = dy + ONE;
            default:    ;
        endcase
    end
endmodule

// File: rtl/dor_hold_reg.sv
// Module: single output register with valid/ready; holds while stalled.
// Assumes: upstream keeps data stable only while in_valid is high.
module dor_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    // Space exists when empty or when the current entry leaves now.
    always_comb in_ready = !out_valid || out_ready;

    // Occupancy flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (in_ready)
            out_valid <= in_valid;
    end

    // Data capture on a completed input handshake only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_data <= '0;
        else if (in_valid && in_ready)
            out_data <= in_data;
    end
endmodule

// File: rtl/dor_mesh_router.sv
// Module: header stage of a 2D mesh switch using x-then-y relative routing.
// Assumes: offsets are signed hop counts to the destination; the tag is
// opaque and passed through.
module dor_mesh_router
    import mesh_rt_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OFS_W-1:0] in_dx,
    input  logic [OFS_W-1:0] in_dy,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_port,
    output logic [OFS_W-1:0] out_dx,
    output logic [OFS_W-1:0] out_dy,
    output logic [TAG_W-1:0] out_tag
);
    localparam int HDR_W = EXIT_W + 2 * OFS_W + TAG_W;
    localparam logic [OFS_W-1:0] ZERO = '0;
    localparam logic [OFS_W-1:0] ONE  = OFS_W'(1);

    exit_e            sel;
    logic [OFS_W-1:0] dx_next, dy_next;
    logic [HDR_W-1:0] hdr_in, hdr_out;
    logic             take;

    dor_dir_decode #(.OFS_W(OFS_W)) u_decode (
        .dx  (in_dx),
        .dy  (in_dy),
        .sel (sel)
    );

    dor_offset_step #(.OFS_W(OFS_W)) u_step (
        .sel     (sel),
        .dx      (in_dx),
        .dy      (in_dy),
        .dx_next (dx_next),
        .dy_next (dy_next)
    );

    // Pack the rewritten header for the output register.
    always_comb hdr_in = {sel, dx_next, dy_next, in_tag};

    dor_hold_reg #(.W(HDR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (hdr_in),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (hdr_out)
    );

    // Unpack the registered header onto the ports.
    always_comb {out_port, out_dx, out_dy, out_tag} = hdr_out;

    // Input handshake completion, used by the checks below.
    always_comb take = in_valid && in_ready;

    AST_EAST_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_dx[OFS_W-1] && in_dx != ZERO) |=>
        (out_port == 3'd1 && out_dx == $past(in_dx) - ONE && out_dy == $past(in_dy))); // R1

    AST_WEST_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_dx[OFS_W-1]) |=>
        (out_port == 3'd2 && out_dx == $past(in_dx) + ONE && out_dy == $past(in_dy))); // R1

    AST_LOCAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port == 3'd0) |-> (out_dx == ZERO && out_dy == ZERO)); // R3

    AST_TAG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (out_valid && out_tag == $past(in_tag))); // R4

    AST_X_BEFORE_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_port == 3'd3 || out_port == 3'd4)) |-> (out_dx == ZERO)); // R5

    AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (!out_valid || out_ready)); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_port) && $stable(out_dx) && $stable(out_dy) && $stable(out_tag))); // R7

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R8
endmodule

// File: tb/dor_mesh_router_tb.sv
// Bench: behavioural reference model advanced on rising edges, outputs
// compared on every falling edge.
module dor_mesh_router_tb_top;
    localparam int OFS_W = 8;
    localparam int TAG_W = 16;
    localparam int RAND_CYCLES = 4000;
    localparam int WATCHDOG = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [OFS_W-1:0] in_dx = '0;
    logic [OFS_W-1:0] in_dy = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [2:0]       out_port;
    logic [OFS_W-1:0] out_dx;
    logic [OFS_W-1:0] out_dy;
    logic [TAG_W-1:0] out_tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state.
    bit             m_valid = 1'b0;
    int             m_port = 0;
    int             m_dx = 0;
    int             m_dy = 0;
    logic [TAG_W-1:0] m_tag = '0;
    bit             m_stalled = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    dor_mesh_router #(.OFS_W(OFS_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_dx(in_dx), .in_dy(in_dy), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_dx(out_dx), .out_dy(out_dy), .out_tag(out_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Model step on each rising edge, from the requirements.
    always @(posedge clk) begin
        int sdx, sdy;
        if (!rst_n) begin
            m_valid = 1'b0;
            m_stalled = 1'b0;
        end else begin
            m_stalled = m_valid && !out_ready;
            if (in_valid && (!m_valid || out_ready)) begin
                sdx = $signed(in_dx);
                sdy = $signed(in_dy);
                m_valid = 1'b1;
                m_tag = in_tag;
                m_dx = sdx;
                m_dy = sdy;
                if (sdx > 0)      begin m_port = 1; m_dx = sdx - 1; end
                else if (sdx < 0) begin m_port = 2; m_dx = sdx + 1; end
                else if (sdy > 0) begin m_port = 3; m_dy = sdy - 1; end
                else if (sdy < 0) begin m_port = 4; m_dy = sdy + 1; end
                else              m_port = 0;
            end else if (out_ready) begin
                m_valid = 1'b0;
            end
        end
    end

    // Compare all outputs against the model.
    task automatic compare();
        string rq;
        chk(out_valid == m_valid, "R6 out_valid", int'(out_valid), int'(m_valid));
        if (m_valid && out_valid) begin
            case (m_port)
                0: rq = "R3";
                1, 2: rq = "R1";
                default: rq = "R2";
            endcase
            if (m_stalled) rq = {rq, "/R7 stall"};
            if (m_dx == 127 || m_dx == -127 || m_dy == 127 || m_dy == -127
                || m_dx == 126 || m_dy == 126)
                rq = {rq, "/R9 edge"};
            chk(int'(out_port) == m_port, {rq, " port"}, int'(out_port), m_port);
            chk(int'($signed(out_dx)) == m_dx, {rq, " dx"}, int'($signed(out_dx)), m_dx);
            chk(int'($signed(out_dy)) == m_dy, {rq, " dy"}, int'($signed(out_dy)), m_dy);
            chk(out_tag == m_tag, "R4 tag", int'(out_tag), int'(m_tag));
            if (m_port == 3 || m_port == 4)
                chk(out_dx == '0, "R5 dx zero on y exit", int'(out_dx), 0);
        end
    endtask

    function automatic int pick();
        int r = int'($urandom % 8);
        case (r)
            0: return 0;
            1: return 127;
            2: return -128;
            3: return 1;
            4: return -1;
            5: return 0;
            default: return int'($urandom % 256) - 128;
        endcase
    endfunction

    task automatic drive(input bit v, input int dx, input int dy, input bit rdy);
        in_valid = v;
        in_dx = OFS_W'(dx);
        in_dy = OFS_W'(dy);
        in_tag = TAG_W'($urandom);
        out_ready = rdy;
        #1;
        chk(in_ready == (!m_valid || out_ready), "R6 in_ready", int'(in_ready),
            int'(!m_valid || out_ready));
    endtask

    // Watchdog.
    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dvec[14][2] = '{'{3, 5}, '{-4, 2}, '{0, 6}, '{0, -6}, '{0, 0},
                            '{127, 0}, '{-128, 0}, '{0, 127}, '{0, -128},
                            '{127, -128}, '{-128, 127}, '{1, 0}, '{0, 1}, '{-1, -1}};
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset idle", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 after reset", int'(out_valid), 0);
        // Directed: each branch and the extreme offsets (R1 R2 R3 R9).
        foreach (dvec[i]) begin
            drive(1'b1, dvec[i][0], dvec[i][1], 1'b1);
            @(negedge clk);
            compare();
        end
        // Directed stall: header held three cycles (R7).
        drive(1'b1, 9, -2, 1'b0);
        @(negedge clk); compare();
        for (int k = 0; k < 3; k++) begin
            drive(1'b1, -5, 4, 1'b0);
            @(negedge clk); compare();
        end
        drive(1'b0, 0, 0, 1'b1);
        @(negedge clk); compare();
        // Random traffic with random backpressure.
        for (int c = 0; c < RAND_CYCLES; c++) begin
            drive(($urandom % 4) != 0, pick(), pick(), ($urandom % 3) != 0);
            @(negedge clk);
            compare();
        end
        // Mid-run reset empties the output (R8).
        drive(1'b1, 2, 2, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset clears", int'(out_valid), 0);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule